// File: doc/BRIEF.md
# Gated Clock Divider Output Stage

This block divides a free-running master clock by a power of two, chosen by a small code, and passes the divided waveform to a tri-state output pad under control of an enable input. Rising enable is lined up with the divider phase, so the pad never shows a sliver pulse and the first high pulse always has its full width. Falling enable forces the pad inactive one master cycle later and cuts short any high pulse in progress.

A configuration bit selects how the pad behaves while disabled. It can be driven low, or it can be released to high impedance so that several such outputs can share one wired-OR line. The pad is described by a data bit and a drive-enable bit. The divider counter runs at all times. A new divide code takes effect only when a divider period starts.

The enable path is a three-state machine. `ST_OFF` is disabled. `ST_ARM` is enabled and waiting for a period boundary. `ST_ON` drives the divided waveform. Its transitions are:
- OFF→ON with phase restart, for ratios of 4 and above.
- OFF→ON at a boundary, for ratios 1 and 2 when the next count value is zero.
- OFF→ARM, for ratios 1 and 2 between boundaries.
- ARM→ON, when a boundary arrives or the ratio becomes 4 or more.
- ARM→OFF and ON→OFF, when enable is low.

Top module: `gated_div_out`

## Requirements
- R1: During and after reset, `out_data` is 0, and `out_oe` equals the inverse of `hiz_sel` (the disabled state).
- R2: Code k gives ratio 2^k. For k ≥ 1 the enabled waveform repeats every 2^k cycles, high for 2^(k-1) and low for 2^(k-1). For k = 0 the enabled output stays high.
- R3: While the output is active (enabled and out of the wait state), `out_oe` is 1, whatever the value of `hiz_sel`.
- R4: With `hiz_sel` = 1 and `en` sampled low, the next cycle shows `out_oe` = 0 and `out_data` = 0.
- R5: With `hiz_sel` = 0 and `en` sampled low, the next cycle shows `out_oe` = 1 and `out_data` = 0.
- R6: A clock edge that samples `en` low sets `out_data` to 0 at that edge, even in the middle of a high pulse.
- R7: For codes 2 and above, `out_data` goes high at the first edge that samples `en` high, with the divider phase restarted. That first pulse is 2^(k-1) cycles wide.
- R8: For codes 0 and 1, the output becomes active at the first period boundary after `en` is sampled high, within one output period (1 or 2 cycles). Until then the pad stays in the R4/R5 disabled state.
- R9: Every high pulse ends after exactly 2^(k-1) cycles unless a low `en` cuts it short.
- R10: A change of `div_code` while running is applied at the next period start. The period in progress completes with the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Output enable, synchronous to `clk` |
| div_code | input | CODE_W | Divide code k, ratio 2^k |
| hiz_sel | input | 1 | 1: release the pad when disabled; 0: drive it low |
| out_data | output | 1 | Pad data value |
| out_oe | output | 1 | Pad drive enable (0 = high impedance) |

## Verification
The assertions take for granted that `en` is synchronous to `clk` and settled at every edge, and that `hiz_sel` does not change inside a cycle that a property spans. The pulse-width property also assumes that `div_code` moves only in ways the boundary rule absorbs. The stimulus drives every input one nanosecond after the rising edge. It changes `hiz_sel` and `div_code` only while the output is disabled and settles for more than two of the longest periods, with one exception: the deliberate mid-period code change that tests R10.

// File: rtl/gdo_pkg.sv
package gdo_pkg;
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ARM = 2'd1,
        ST_ON  = 2'd2
    } gate_state_e;
endpackage

// File: rtl/gdo_phase_ctr.sv
module gdo_phase_ctr #(
    parameter int CODE_W = 3,
    localparam int CNT_W = (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [CODE_W-1:0] code_in,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CODE_W-1:0] code_q,
    output logic [CNT_W-1:0]  cnt_d,
    output logic [CODE_W-1:0] code_d
);
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] last_val;
    logic             at_last;

    always_comb begin
        span     = (CNT_W+1)'(1) << code_q;
        last_val = CNT_W'(span - (CNT_W+1)'(1));
        at_last  = (cnt_q == last_val);
        if (restart || at_last) begin
            cnt_d  = '0;
            code_d = code_in;
        end else begin
            cnt_d  = cnt_q + CNT_W'(1);
            code_d = code_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            code_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            code_q <= code_d;
        end
    end
endmodule

// File: rtl/gdo_gate_fsm.sv
module gdo_gate_fsm
    import gdo_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic        fast_start,
    input  logic        at_boundary,
    output gate_state_e state_q,
    output gate_state_e state_d,
    output logic        restart
);
    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        unique case (state_q)
            ST_OFF: begin
                if (en) begin
                    if (fast_start) begin
                        restart = 1'b1;
                        state_d = ST_ON;
                    end else if (at_boundary) begin
                        state_d = ST_ON;
                    end else begin
                        state_d = ST_ARM;
                    end
                end
            end
            ST_ARM: begin
                if (!en) begin
                    state_d = ST_OFF;
                end else if (fast_start) begin
                    restart = 1'b1;
                    state_d = ST_ON;
                end else if (at_boundary) begin
                    state_d = ST_ON;
                end
            end
            ST_ON: begin
                if (!en) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/gated_div_out.sv
module gated_div_out
    import gdo_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [CODE_W-1:0] div_code,
    input  logic              hiz_sel,
    output logic              out_data,
    output logic              out_oe
);
    localparam int CNT_W = (1 << CODE_W) - 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_d;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] code_d;
    logic              restart;
    logic              fast_start;
    logic              at_boundary;
    logic              level_d;
    logic [CNT_W:0]    half_d;
    logic              out_q;
    gate_state_e       state_q;
    gate_state_e       state_d;

    assign fast_start  = (div_code >= CODE_W'(2));
    assign at_boundary = (cnt_d == '0);

    gdo_phase_ctr #(.CODE_W(CODE_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .code_in (div_code),
        .cnt_q   (cnt_q),
        .code_q  (code_q),
        .cnt_d   (cnt_d),
        .code_d  (code_d)
    );

    gdo_gate_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .fast_start  (fast_start),
        .at_boundary (at_boundary),
        .state_q     (state_q),
        .state_d     (state_d),
        .restart     (restart)
    );

    always_comb begin
        half_d  = ((CNT_W+1)'(1) << code_d) >> 1;
        level_d = (code_d == '0) || ((cnt_d & half_d[CNT_W-1:0]) == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= (state_d == ST_ON) && level_d;
    end

    assign out_data = out_q;
    assign out_oe   = (state_q == ST_ON) || !hiz_sel;
endmodule

// File: rtl/gdo_chk.sv
module gdo_chk
    import gdo_pkg::*;
#(
    parameter int CODE_W = 3,
    localparam int CNT_W = (1 << CODE_W) - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [CODE_W-1:0] div_code,
    input logic              hiz_sel,
    input logic              out_data,
    input logic              out_oe,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CODE_W-1:0] code_q,
    input gate_state_e       state_q
);
    logic [CNT_W:0]   hi_run;
    logic [CNT_W:0]   span_q;
    logic [CNT_W:0]   half_q;

    assign span_q = (CNT_W+1)'(1) << code_q;
    assign half_q = span_q >> 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hi_run <= '0;
        else if (out_data) hi_run <= hi_run + (CNT_W+1)'(1);
        else               hi_run <= '0;
    end

    p_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !out_data);

    p_idle_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (out_oe != hiz_sel));

    p_driven_when_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_data |-> out_oe);

    p_fast_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ON && en && div_code >= CODE_W'(2)) |=> out_data);

    p_code_at_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != $past(code_q)) |-> (cnt_q == '0));

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, cnt_q} < span_q));

    p_full_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(out_data) && $past(en)) |-> (hi_run == half_q));
endmodule

bind gated_div_out gdo_chk #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .div_code (div_code),
    .hiz_sel  (hiz_sel),
    .out_data (out_data),
    .out_oe   (out_oe),
    .cnt_q    (cnt_q),
    .code_q   (code_q),
    .state_q  (state_q)
);

// File: tb/gated_div_out_tb.sv
`timescale 1ns/1ps
module gated_div_out_tb;
    localparam int CODE_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              en = 1'b0;
    logic [CODE_W-1:0] div_code = '0;
    logic              hiz_sel = 1'b1;
    logic              out_data;
    logic              out_oe;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gated_div_out #(.CODE_W(CODE_W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .div_code (div_code),
        .hiz_sel  (hiz_sel),
        .out_data (out_data),
        .out_oe   (out_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic meas(input bit lvl, input int cap, output int n);
        n = 0;
        while (out_data == lvl && n < cap) begin
            n++;
            tick();
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            report();
            $finish;
        end
    end

    initial begin
        int k, h, l, r;
        bit wait_ok;
        // R1: reset state in both pad modes
        div_code = 3;
        repeat (3) tick();
        chk(out_data == 1'b0, "R1 data", out_data, 0);
        chk(out_oe == 1'b0, "R1 oe hiz", out_oe, 0);
        hiz_sel = 1'b0;
        #1;
        chk(out_oe == 1'b1, "R1 oe low", out_oe, 1);
        tick();
        rst_n = 1'b1;

        for (int hz = 0; hz < 2; hz++) begin
            for (int c = 0; c < 8; c++) begin
                for (int off = 0; off < 3; off++) begin
                    int n;
                    n = 1 << c;
                    en = 1'b0;
                    hiz_sel = hz[0];
                    div_code = c[CODE_W-1:0];
                    repeat (300 + off) tick();
                    // R4 / R5: disabled pad state
                    chk(out_data == 1'b0, hz ? "R4 data" : "R5 data", out_data, 0);
                    chk(out_oe == !hz[0], hz ? "R4 oe" : "R5 oe", out_oe, !hz[0]);
                    en = 1'b1;
                    k = 0;
                    wait_ok = 1;
                    do begin
                        tick();
                        k++;
                        if (!out_data && out_oe != !hz[0]) wait_ok = 0;
                    end while (!out_data && k < 400);
                    if (c >= 2) chk(k == 1, "R7 latency", k, 1);
                    else chk(k <= ((c == 0) ? 1 : 2), "R8 latency", k, (c == 0) ? 1 : 2);
                    chk(wait_ok, "R8 wait state", wait_ok, 1);
                    chk(out_oe == 1'b1, "R3 oe active", out_oe, 1);
                    if (c == 0) begin
                        meas(1'b1, 20, h);
                        chk(h == 20, "R2 ratio1 high", h, 20);
                    end else begin
                        meas(1'b1, 300, h);
                        chk(h == n / 2, c >= 2 ? "R7 first pulse" : "R9 first pulse", h, n / 2);
                        meas(1'b0, 300, l);
                        chk(l == n / 2, "R2 low half", l, n / 2);
                        meas(1'b1, 300, h);
                        chk(h == n / 2, "R9 pulse", h, n / 2);
                    end
                    if (c >= 2) begin
                        meas(1'b0, 300, l);
                        tick();
                        en = 1'b0;
                        tick();
                        chk(out_data == 1'b0, "R6 truncate", out_data, 0);
                        chk(out_oe == !hz[0], "R6 pad", out_oe, !hz[0]);
                    end else begin
                        en = 1'b0;
                        tick();
                        chk(out_data == 1'b0, "R6 off", out_data, 0);
                    end
                end
            end
        end

        // R10: mid-period code change 8 -> 4
        hiz_sel = 1'b0;
        div_code = 3;
        en = 1'b0;
        repeat (300) tick();
        en = 1'b1;
        k = 0;
        do begin
            tick();
            k++;
        end while (!out_data && k < 400);
        chk(k == 1, "R7 latency r10 setup", k, 1);
        tick();
        tick();
        div_code = 2;
        meas(1'b1, 300, r);
        chk(2 + r == 4, "R10 old high", 2 + r, 4);
        meas(1'b0, 300, l);
        chk(l == 4, "R10 old low", l, 4);
        meas(1'b1, 300, h);
        chk(h == 2, "R10 new high", h, 2);
        meas(1'b0, 300, l);
        chk(l == 2, "R10 new low", l, 2);
        en = 1'b0;
        tick();

        done = 1;
        report();
        $finish;
    end
endmodule